// File: doc/BRIEF.md
# Receiver Polling Power Sequencer

This block duty-cycles a wake-up radio receiver to save power. It loops through three phases. In the sleep phase the analog enable is held low. In the wake phase the enable is raised and the front end is given time to settle. In the check phase the block looks at incoming bits. The check phase ends at once on the first bit that fails the validity test, and the block then goes back to sleep. After a programmed number of consecutive good bits, the block declares a valid telegram instead. It then holds the receiver on until the host sends it back to polling.

The sleep length is a 5-bit word multiplied by an extension factor of 1 or 8 and by a fixed unit of base clocks (1024 by default). The wake phase lasts a fixed number of periods of a derived tick. That tick runs once every 8, 4, 2 or 1 base clocks, as chosen by a 2-bit baud-range field. Each control input is sampled only at the edge that enters the phase using it, so a change made mid-phase does not disturb the phase already running. Bit validity is measured outside the block and arrives as per-bit strobes.

Top module: `rx_poll_seq`

## Requirements
- R1: While `rst_ni` is low, `phase_o` is 0, and `rx_en_o`, `xtick_o` and `data_valid_o` are all 0. After reset is released, the first clock edge loads the sleep timer and the sleep phase then runs its full length, so the first wake comes UNIT+1 edges after release for a sleep word of 1 with factor 1.
- R2: `phase_o` encodes sleep as 0, wake as 1, check as 2 and telegram-hold as 3. Sleep is followed only by wake, and wake only by check or, on restart, by sleep.
- R3: Counted from the clock edge that enters sleep, the block leaves sleep exactly W × F × UNIT_CLKS edges later. W is the sleep word and F is the extension factor.
- R4: F is 8 when `xsleep_std_i` is 1 and 1 when it is 0.
- R5: A sleep word of 0 gives the same sleep length as a sleep word of 1.
- R6: `rx_en_o` is 0 in every sleep cycle and 1 in every wake, check and hold cycle.
- R7: In the non-sleep phases, `xtick_o` pulses once every 8, 4, 2 or 1 base clocks for `baud_range_i` = 0, 1, 2 or 3. `xtick_o` is never high during sleep.
- R8: The wake phase lasts STARTUP_TICKS tick periods, which is STARTUP_TICKS × divisor edges from wake entry to check entry.
- R9: Valid and invalid strobes have no effect during sleep and wake.
- R10: An invalid strobe in the check phase returns the block to sleep at the next edge. If a valid strobe arrives in the same cycle, the invalid strobe wins.
- R11: In the check phase, N consecutive valid strobes move the block to hold (`phase_o`=3, `data_valid_o`=1). N is `nbit_i`, and an `nbit_i` of 0 counts as 1. The block stays in hold until restart.
- R12: `poll_restart_i` returns the block from wake, check or hold to sleep at the next edge. It has no effect during sleep.
- R13: The sleep word and extension bit are sampled at sleep entry, the baud range at wake entry, and `nbit_i` at check entry. Later changes do not affect the phase in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_val_i | input | SLEEP_W | Sleep length word, in units |
| xsleep_std_i | input | 1 | Selects the 8x sleep extension |
| baud_range_i | input | RANGE_W | Tick divisor select (0 gives /8 through 3 gives /1) |
| nbit_i | input | NBIT_W | Number of consecutive good bits needed |
| bit_valid_i | input | 1 | Strobe: current bit passed the validity test |
| bit_invalid_i | input | 1 | Strobe: current bit failed the validity test |
| poll_restart_i | input | 1 | Return to the polling loop |
| rx_en_o | output | 1 | Signal-processing enable |
| xtick_o | output | 1 | Baud-range-dependent tick |
| data_valid_o | output | 1 | Valid telegram detected |
| phase_o | output | 2 | Current phase |

## Verification
The bench changes the sleep word, extension bit, baud range and bit count in the middle of the phases that had already sampled them. A design that reads these inputs live would produce wrong sleep lengths, wrong wake lengths or wrong tick counts, or it would enter hold too early or too late. The bench sends valid strobes during sleep and invalid strobes during wake. A design that does not gate these strobes would either pre-load the good-bit counter or abort the wake phase. Other targeted cases are:
- a sleep word of 0, which a naive design would turn into a stall or a wrapped count;
- an `nbit_i` of 0;
- simultaneous valid and invalid strobes, where a wrong priority would declare a telegram;
- a restart pulse during sleep, which must not reload the timer.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;
  typedef enum logic [1:0] {
    PH_SLEEP = 2'd0,
    PH_WAKE  = 2'd1,
    PH_CHECK = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  localparam int unsigned XS_SHIFT = 3;  // 8x extension as a shift
endpackage

// File: rtl/rx_poll_sleep_tmr.sv
module rx_poll_sleep_tmr
  import rx_poll_pkg::*;
#(
  parameter int unsigned SLEEP_W   = 5,
  parameter int unsigned UNIT_CLKS = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SLEEP_W-1:0] sleep_i,
  input  logic               xsleep_i,
  output logic               expired_o
);
  localparam int unsigned UNIT_W = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;
  localparam int unsigned CNT_W  = SLEEP_W + XS_SHIFT + UNIT_W;

  logic [SLEEP_W-1:0] units;
  logic [CNT_W-1:0]   scaled, total, cnt_q;

  // zero word clamps to one unit so the loop never stalls
  assign units  = (sleep_i == '0) ? SLEEP_W'(1) : sleep_i;
  assign scaled = xsleep_i ? (CNT_W'(units) << XS_SHIFT) : CNT_W'(units);
  assign total  = scaled * CNT_W'(UNIT_CLKS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= total - CNT_W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  AST_SLEEP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R3
  AST_SLEEP_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !expired_o); // R5
endmodule

// File: rtl/rx_poll_tick.sv
module rx_poll_tick #(
  parameter int unsigned RANGE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               run_i,
  input  logic [RANGE_W-1:0] range_i,
  output logic               tick_o
);
  localparam int unsigned CW = (1 << RANGE_W) - 1;

  logic [RANGE_W-1:0] sh_q;
  logic [CW-1:0]      cnt_q, last;

  // divisor = 2^(CW - range): range 0 slowest, max range every clock
  assign last   = ~({CW{1'b1}} << sh_q);
  assign tick_o = run_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      sh_q  <= RANGE_W'(CW) - range_i;
    end else if (run_i) begin
      cnt_q <= (cnt_q == last) ? '0 : cnt_q + CW'(1);
    end
  end

  AST_TICK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last); // R7
  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i && tick_o && sh_q != '0) |=> !tick_o); // R7
endmodule

// File: rtl/rx_poll_bitchk.sv
module rx_poll_bitchk #(
  parameter int unsigned NBIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NBIT_W-1:0] n_i,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic              invalid_i,
  output logic              hit_o,
  output logic              fail_o
);
  logic [NBIT_W-1:0] tgt_q, cnt_q;
  logic              good;

  assign good   = en_i && valid_i && !invalid_i;  // invalid has priority
  assign fail_o = en_i && invalid_i;
  assign hit_o  = good && (cnt_q == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      tgt_q <= (n_i == '0) ? '0 : n_i - NBIT_W'(1);
      cnt_q <= '0;
    end else if (good && cnt_q != tgt_q) begin
      cnt_q <= cnt_q + NBIT_W'(1);
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= tgt_q); // R11
  AST_RUN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good && !hit_o && !start_i) |=> (cnt_q == $past(cnt_q) + NBIT_W'(1))); // R11
endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq
  import rx_poll_pkg::*;
#(
  parameter int unsigned SLEEP_W       = 5,
  parameter int unsigned UNIT_CLKS     = 1024,
  parameter int unsigned RANGE_W       = 2,
  parameter int unsigned NBIT_W        = 4,
  parameter int unsigned STARTUP_TICKS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SLEEP_W-1:0] sleep_val_i,
  input  logic               xsleep_std_i,
  input  logic [RANGE_W-1:0] baud_range_i,
  input  logic [NBIT_W-1:0]  nbit_i,
  input  logic               bit_valid_i,
  input  logic               bit_invalid_i,
  input  logic               poll_restart_i,
  output logic               rx_en_o,
  output logic               xtick_o,
  output logic               data_valid_o,
  output logic [1:0]         phase_o
);
  localparam int unsigned WK_W = (STARTUP_TICKS > 1) ? $clog2(STARTUP_TICKS) : 1;
  localparam logic [WK_W-1:0] WK_LAST = WK_W'(STARTUP_TICKS - 1);

  phase_e          phase_q;
  logic            arm_q;
  logic [WK_W-1:0] wk_cnt_q;
  logic            expired, tick, hit, fail;
  logic            sleep_load, wake_start, check_start, active;

  assign active      = (phase_q != PH_SLEEP);
  assign sleep_load  = (!active && arm_q) || (active && (poll_restart_i || fail));
  assign wake_start  = !active && !arm_q && expired;
  assign check_start = (phase_q == PH_WAKE) && !poll_restart_i && tick && (wk_cnt_q == WK_LAST);

  rx_poll_sleep_tmr #(.SLEEP_W(SLEEP_W), .UNIT_CLKS(UNIT_CLKS)) u_sleep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (sleep_load),
    .sleep_i  (sleep_val_i),
    .xsleep_i (xsleep_std_i),
    .expired_o(expired)
  );

  rx_poll_tick #(.RANGE_W(RANGE_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(wake_start),
    .run_i  (active),
    .range_i(baud_range_i),
    .tick_o (tick)
  );

  rx_poll_bitchk #(.NBIT_W(NBIT_W)) u_bits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (check_start),
    .n_i      (nbit_i),
    .en_i     (phase_q == PH_CHECK),
    .valid_i  (bit_valid_i),
    .invalid_i(bit_invalid_i),
    .hit_o    (hit),
    .fail_o   (fail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_SLEEP;
      arm_q    <= 1'b1;
      wk_cnt_q <= '0;
    end else begin
      unique case (phase_q)
        PH_SLEEP: begin
          if (arm_q) arm_q <= 1'b0;
          else if (expired) begin
            phase_q  <= PH_WAKE;
            wk_cnt_q <= '0;
          end
        end
        PH_WAKE: begin
          if (poll_restart_i) phase_q <= PH_SLEEP;
          else if (tick) begin
            if (wk_cnt_q == WK_LAST) phase_q <= PH_CHECK;
            else wk_cnt_q <= wk_cnt_q + WK_W'(1);
          end
        end
        PH_CHECK: begin
          if (poll_restart_i || fail) phase_q <= PH_SLEEP;
          else if (hit)               phase_q <= PH_HOLD;
        end
        PH_HOLD: begin
          if (poll_restart_i) phase_q <= PH_SLEEP;
        end
        default: phase_q <= PH_SLEEP;
      endcase
    end
  end

  assign rx_en_o      = active;
  assign xtick_o      = tick;
  assign data_valid_o = (phase_q == PH_HOLD);
  assign phase_o      = phase_q;

  AST_ORDER_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SLEEP) |=> (phase_q == PH_SLEEP || phase_q == PH_WAKE)); // R2
  AST_ORDER_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAKE) |=> (phase_q != PH_HOLD)); // R2
  AST_NO_TICK_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SLEEP) |-> !xtick_o); // R7
  AST_SLEEP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SLEEP && !expired) |=> (phase_q == PH_SLEEP)); // R12
  AST_FAIL_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CHECK && bit_invalid_i) |=> (phase_q == PH_SLEEP)); // R10
  AST_RESTART_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && poll_restart_i) |=> (phase_q == PH_SLEEP)); // R12
  AST_HOLD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && !poll_restart_i) |=> (phase_q == PH_HOLD)); // R11
endmodule

// File: tb/rx_poll_seq_test.sv
module rx_poll_seq_test;
  localparam int UNIT = 16;
  localparam int ST   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] sleep_val = '0;
  logic       xs_std = 1'b0;
  logic [1:0] brange = '0;
  logic [3:0] nbit = '0;
  logic       bv = 1'b0, binv = 1'b0, restart = 1'b0;
  logic       rx_en, xtick, dvalid;
  logic [1:0] phase;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rx_poll_seq #(.UNIT_CLKS(UNIT), .STARTUP_TICKS(ST)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_val_i(sleep_val), .xsleep_std_i(xs_std),
    .baud_range_i(brange), .nbit_i(nbit), .bit_valid_i(bv), .bit_invalid_i(binv),
    .poll_restart_i(restart), .rx_en_o(rx_en), .xtick_o(xtick),
    .data_valid_o(dvalid), .phase_o(phase)
  );

  // fields: [15:11] sleep word, [10] ext, [9:8] range, [7:4] nbit, [3:0] good bits sent
  localparam logic [15:0] ROWS [8] = '{
    16'h1033, 16'h0121, 16'h0E11, 16'h1B42,
    16'h0C01, 16'hF955, 16'h17F0, 16'h2222
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_sleep(input int exp_t, input string req);
    int cnt = 0;
    int bad = 0;
    bv = 1'b1;  // must be ignored (R9)
    while (phase == 2'd0 && cnt < 6000) begin
      if (rx_en || xtick) bad = 1;
      step();
      cnt++;
    end
    bv = 1'b0;
    chk(req, cnt, exp_t);
    chk("R6 R7 enable and tick low in sleep", bad, 0);
    chk("R2 sleep followed by wake", phase, 1);
  endtask

  task automatic run_wake(input int div);
    int cnt = 0;
    int ticks = 0;
    int bad = 0;
    binv = 1'b1;  // must be ignored (R9)
    while (phase == 2'd1 && cnt < 1000) begin
      if (xtick) ticks++;
      if (!rx_en) bad = 1;
      step();
      cnt++;
    end
    binv = 1'b0;
    chk("R8 R13 wake length", cnt, ST * div);
    chk("R7 tick count in wake", ticks, ST);
    chk("R6 enable high in wake", bad, 0);
    chk("R9 invalid ignored in wake, check reached", phase, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit prev_hold;
    // R1: reset state
    sleep_val = 5'd1; xs_std = 1'b0; brange = 2'd3; nbit = 4'd1;
    step(); step();
    chk("R1 phase in reset", phase, 0);
    chk("R1 enable in reset", rx_en, 0);
    chk("R1 tick in reset", xtick, 0);
    chk("R1 data valid in reset", dvalid, 0);
    rst_n = 1'b1;
    run_sleep(UNIT + 1, "R1 R3 first sleep after reset");
    run_wake(1);
    bv = 1'b1; step(); bv = 1'b0;
    chk("R11 single bit telegram", phase, 3);
    prev_hold = 1'b1;

    for (int r = 0; r < 8; r++) begin
      logic [4:0] s;
      logic       x;
      logic [1:0] rg;
      logic [3:0] n;
      int k, exp_t, div, neff;
      bit hold;
      s = ROWS[r][15:11]; x = ROWS[r][10]; rg = ROWS[r][9:8];
      n = ROWS[r][7:4];  k = int'(ROWS[r][3:0]);
      exp_t = ((s == 0) ? 1 : int'(s)) * (x ? 8 : 1) * UNIT;
      div   = 8 >> rg;
      neff  = (n == 0) ? 1 : int'(n);
      sleep_val = s; xs_std = x; brange = rg; nbit = n;
      if (prev_hold) restart = 1'b1; else binv = 1'b1;
      step();
      restart = 1'b0; binv = 1'b0;
      chk(prev_hold ? "R12 restart from hold" : "R10 invalid ends check", phase, 0);
      sleep_val = ~s; xs_std = ~x;  // R13 mid-phase change
      run_sleep(exp_t, "R3 R4 R5 R13 sleep length");
      brange = ~rg;
      run_wake(div);
      nbit = ~n;
      for (int j = 0; j < k; j++) begin
        bv = 1'b1; step();
      end
      bv = 1'b0;
      hold = (k >= neff);
      chk("R11 R13 phase after good bits", phase, hold ? 3 : 2);
      chk("R11 data valid", dvalid, hold ? 1 : 0);
      if (hold) begin
        step(); step(); step();
        chk("R11 hold is sticky", phase, 3);
      end
      prev_hold = hold;
    end

    // R12: restart in sleep has no effect
    sleep_val = 5'd1; xs_std = 1'b0; brange = 2'd3; nbit = 4'd1;
    restart = 1'b1; step(); restart = 1'b0;
    repeat (4) step();
    restart = 1'b1; step(); restart = 1'b0;
    run_sleep(UNIT - 5, "R12 restart ignored in sleep");
    // R12: restart during wake
    restart = 1'b1; step(); restart = 1'b0;
    chk("R12 restart from wake", phase, 0);
    chk("R12 enable off after restart", rx_en, 0);
    run_sleep(UNIT, "R3 sleep after wake restart");
    run_wake(1);
    // R10: invalid wins over valid
    bv = 1'b1; binv = 1'b1; step(); bv = 1'b0; binv = 1'b0;
    chk("R10 invalid wins over valid", phase, 0);
    chk("R10 no data valid", dvalid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule